// File: doc/BRIEF.md
# Interrupt Enable and Pending State Bank

This block is a memory-mapped bank of per-interrupt state for a parameterised number of interrupt sources. Each source has an enable bit and a pending bit. Software updates them through four address windows: set-enable, clear-enable, set-pending and clear-pending. A written 1 acts on the matching interrupt and a written 0 leaves it alone. In every window, data bit k of an access refers to interrupt ID (byte offset within the window × 8) + k.

Each source is built as either edge-sensitive or level-sensitive, chosen per bit by a parameter. An edge source latches pending on a rising edge of its line. A level source has no stored pending bit. Its pending state is the registered line level OR a software-pending latch. Software sets that latch through the set-pending window. A clear-pending write on a level source clears only the latch, so pending then follows the line again.

Reads return one enable or pending bit per covered interrupt, registered one cycle after the request. Priority, targeting and delivery to a processor belong to other blocks, which consume the `enOut` and `pendOut` vectors.

Top module: `irq_state_bank`

## Requirements
- R1: Reset clears all enable bits, edge pending bits and software-pending latches. In the cycle after a reset cycle, `enOut` and `pendOut` are all zero.
- R2: Address bits `reqAddr[ADDR_W-1:OFF_W]` select the window: 0 = set-enable, 1 = clear-enable, 2 = set-pending, 3 = clear-pending. A write to window 0 sets the enable of every covered interrupt whose data bit is 1, and leaves all other enables unchanged. An enable bit never rises except through such a write.
- R3: A write to window 1 clears the enable of every covered interrupt whose data bit is 1. An enable bit never falls except through such a write.
- R4: `reqWord`=0 is a byte access. It uses `reqWdata[7:0]`, covers 8 interrupts and returns them in `rdData[7:0]` with the upper bits zero. `reqWord`=1 is a word access that covers 32 interrupts. Bit k maps to ID offset×8+k. Reads of windows 0 and 1 both return enable bits.
- R5: Interrupt IDs at or above NUM_IRQ read as 0, and writes to them have no effect.
- R6: A word access whose offset has `reqAddr[1:0]` ≠ 0 is rejected. A rejected write changes nothing, and a rejected read returns 0.
- R7: A 1 written to window 2 makes an edge interrupt pending. On a level interrupt it sets the software-pending latch, so pending stays 1 after the line drops.
- R8: A 1 written to window 3 clears the pending bit of an edge interrupt.
- R9: A 1 written to window 3 on a level interrupt clears its software-pending latch. Its pending state then equals the registered line level.
- R10: A rising edge on an edge line sets pending one cycle later. A level interrupt's pending state equals the line level from the previous cycle OR its latch.
- R11: If an edge line rises in the same cycle as a clear-pending write to that interrupt, the interrupt ends up pending.
- R12: A read request yields `rdValid`=1 and the data in `rdData` in the next cycle. Reads of windows 2 and 3 both return pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Window select (top 2 bits) and byte offset |
| reqWord | input | 1 | 1 = 32-bit access, 0 = byte access |
| reqWdata | input | 32 | Write data, bit k maps to ID offset×8+k |
| irqLine | input | NUM_IRQ | Interrupt input lines |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| enOut | output | NUM_IRQ | Current enable bits |
| pendOut | output | NUM_IRQ | Current pending state |

## Verification
The bench sweeps every byte offset in all four windows, and also the word offsets. This exposes any design that maps an offset to the wrong interrupt ID, or that leaks state from beyond NUM_IRQ into the read data. It checks that a clear-pending write on a level source falls back to the line level. A design that zeroes that bit would drop an interrupt that is still asserted. It checks that a set-pending on a level source survives the line dropping, which catches a design that writes only the stored pending bit. It also drives a line rise in the same cycle as a clear of that interrupt, and a misaligned word access. A wrong priority loses the new edge, and a missing alignment check corrupts neighbouring enables.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int ID_W = 16;

  typedef enum logic [1:0] {
    WIN_SET_EN   = 2'd0,
    WIN_CLR_EN   = 2'd1,
    WIN_SET_PEND = 2'd2,
    WIN_CLR_PEND = 2'd3
  } bankWin_e;

  typedef struct packed {
    logic            wrSetEn;
    logic            wrClrEn;
    logic            wrSetPend;
    logic            wrClrPend;
    logic            rdReq;
    logic            rdIsPend;
    logic [5:0]      laneCnt;
    logic [ID_W-1:0] baseId;
  } bankStrb_t;
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [OFF_W+1:0]     reqAddr,
  input  logic                 reqWord,
  output bankStrb_t            strb
);
  localparam int ADDR_W = OFF_W + 2;

  bankWin_e           win;
  logic [OFF_W-1:0]   offset;
  logic               aligned;
  logic               accept;
  logic               doWrite;

  assign win     = bankWin_e'(reqAddr[ADDR_W-1:OFF_W]);
  assign offset  = reqAddr[OFF_W-1:0];
  assign aligned = !reqWord || (offset[1:0] == 2'b00);
  assign accept  = reqValid && aligned;
  assign doWrite = accept && reqWrite;

  always_comb begin
    strb           = '0;
    strb.baseId    = ID_W'({offset, 3'b000});
    strb.laneCnt   = !accept ? 6'd0 : (reqWord ? 6'd32 : 6'd8);
    strb.rdReq     = reqValid && !reqWrite;
    strb.rdIsPend  = (win == WIN_SET_PEND) || (win == WIN_CLR_PEND);
    strb.wrSetEn   = doWrite && (win == WIN_SET_EN);
    strb.wrClrEn   = doWrite && (win == WIN_CLR_EN);
    strb.wrSetPend = doWrite && (win == WIN_SET_PEND);
    strb.wrClrPend = doWrite && (win == WIN_CLR_PEND);
  end
endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath
  import irq_bank_pkg::*;
#(
  parameter int                 NUM_IRQ    = 64,
  parameter logic [NUM_IRQ-1:0] LEVEL_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  bankStrb_t          strb,
  input  logic [31:0]        reqWdata,
  input  logic [NUM_IRQ-1:0] irqLine,
  output logic               rdValid,
  output logic [31:0]        rdData,
  output logic [NUM_IRQ-1:0] enOut,
  output logic [NUM_IRQ-1:0] pendOut
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] lineQ;
  logic [NUM_IRQ-1:0] enQ;
  logic [NUM_IRQ-1:0] pendVec;
  logic [31:0]        rdVec;

  always_ff @(posedge clk) begin
    if (rst) lineQ <= '0;
    else     lineQ <= irqLine;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic [ID_W-1:0] rel;
    logic            inLane;
    logic            hit;

    assign rel    = ID_W'(i) - strb.baseId;
    assign inLane = (ID_W'(i) >= strb.baseId) && (rel < ID_W'(strb.laneCnt));
    assign hit    = inLane && reqWdata[rel[4:0]];

    always_ff @(posedge clk) begin
      if (rst)                         enQ[i] <= 1'b0;
      else if (hit && strb.wrSetEn)    enQ[i] <= 1'b1;
      else if (hit && strb.wrClrEn)    enQ[i] <= 1'b0;
    end

    if (LEVEL_MASK[i]) begin : g_level
      logic softQ;
      always_ff @(posedge clk) begin
        if (rst)                         softQ <= 1'b0;
        else if (hit && strb.wrSetPend)  softQ <= 1'b1;
        else if (hit && strb.wrClrPend)  softQ <= 1'b0;
      end
      assign pendVec[i] = lineQ[i] | softQ;
    end else begin : g_edge
      logic pendQ;
      logic rise;
      assign rise = irqLine[i] & ~lineQ[i];
      always_ff @(posedge clk) begin
        if (rst)                         pendQ <= 1'b0;
        else if (rise)                   pendQ <= 1'b1;
        else if (hit && strb.wrSetPend)  pendQ <= 1'b1;
        else if (hit && strb.wrClrPend)  pendQ <= 1'b0;
      end
      assign pendVec[i] = pendQ;
    end
  end

  for (genvar k = 0; k < 32; k++) begin : g_rd
    logic [ID_W-1:0] id;
    logic            valid;
    assign id    = strb.baseId + ID_W'(k);
    assign valid = (6'(k) < strb.laneCnt) && (id < ID_W'(NUM_IRQ));
    assign rdVec[k] = valid &&
                      (strb.rdIsPend ? pendVec[id[IDX_W-1:0]] : enQ[id[IDX_W-1:0]]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdReq;
      rdData  <= strb.rdReq ? rdVec : 32'd0;
    end
  end

  assign enOut   = enQ;
  assign pendOut = pendVec;
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int                 NUM_IRQ    = 64,
  parameter int                 WIN_BYTES  = 16,
  parameter logic [NUM_IRQ-1:0] LEVEL_MASK = '0,
  localparam int                OFF_W      = $clog2(WIN_BYTES),
  localparam int                ADDR_W     = OFF_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWord,
  input  logic [31:0]        reqWdata,
  input  logic [NUM_IRQ-1:0] irqLine,
  output logic               rdValid,
  output logic [31:0]        rdData,
  output logic [NUM_IRQ-1:0] enOut,
  output logic [NUM_IRQ-1:0] pendOut
);
  bankStrb_t strb;

  irq_bank_ctrl #(.OFF_W(OFF_W)) ctrlInst (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWord  (reqWord),
    .strb     (strb)
  );

  irq_bank_datapath #(.NUM_IRQ(NUM_IRQ), .LEVEL_MASK(LEVEL_MASK)) dpInst (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .reqWdata (reqWdata),
    .irqLine  (irqLine),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .enOut    (enOut),
    .pendOut  (pendOut)
  );
endmodule

// File: rtl/irq_state_bank_chk.sv
module irq_state_bank_chk #(
  parameter int NUM_IRQ = 64,
  parameter int OFF_W   = 4,
  parameter int ADDR_W  = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               reqValid,
  input logic               reqWrite,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               reqWord,
  input logic               rdValid,
  input logic [NUM_IRQ-1:0] enOut,
  input logic [NUM_IRQ-1:0] pendOut
);
  logic setEnWr;
  logic clrEnWr;
  logic badWordWr;

  assign setEnWr   = reqValid && reqWrite && (reqAddr[ADDR_W-1:OFF_W] == 2'd0);
  assign clrEnWr   = reqValid && reqWrite && (reqAddr[ADDR_W-1:OFF_W] == 2'd1);
  assign badWordWr = reqValid && reqWrite && reqWord && (reqAddr[1:0] != 2'b00);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (enOut == '0 && pendOut == '0));

  assert_en_rise_only_by_set_R2: assert property (@(posedge clk) disable iff (rst)
    !setEnWr |=> ((enOut & ~$past(enOut)) == '0));

  assert_en_fall_only_by_clr_R3: assert property (@(posedge clk) disable iff (rst)
    !clrEnWr |=> (($past(enOut) & ~enOut) == '0));

  assert_misaligned_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    badWordWr |=> $stable(enOut));

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite) |=> rdValid);

  assert_no_read_on_write_R12: assert property (@(posedge clk) disable iff (rst)
    !(reqValid && !reqWrite) |=> !rdValid);
endmodule

bind irq_state_bank irq_state_bank_chk #(
  .NUM_IRQ (NUM_IRQ),
  .OFF_W   (OFF_W),
  .ADDR_W  (ADDR_W)
) chkInst (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqAddr  (reqAddr),
  .reqWord  (reqWord),
  .rdValid  (rdValid),
  .enOut    (enOut),
  .pendOut  (pendOut)
);

// File: tb/irq_state_bank_test.sv
`timescale 1ns/1ps
module irq_state_bank_test;
  localparam int          N   = 64;
  localparam logic [63:0] LVL = 64'hFF00_FF00_FF00_FF00;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid, reqWrite, reqWord;
  logic [5:0]  reqAddr;
  logic [31:0] reqWdata;
  logic [63:0] line;
  logic        rdValid;
  logic [31:0] rdData;
  logic [63:0] enOut, pendOut;

  int total = 0;
  int bad   = 0;

  logic [63:0] enM, pendM, softM, lineQm;

  always #2.5 clk = ~clk;

  irq_state_bank #(.NUM_IRQ(N), .WIN_BYTES(16), .LEVEL_MASK(LVL)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWord(reqWord), .reqWdata(reqWdata),
    .irqLine(line), .rdValid(rdValid), .rdData(rdData),
    .enOut(enOut), .pendOut(pendOut)
  );

  function automatic logic [63:0] expPend();
    return (LVL & (lineQm | softM)) | (~LVL & pendM);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] win, input logic [3:0] off,
                        input logic word, input logic [31:0] data,
                        input logic [63:0] newLine, input string tag);
    logic [31:0] expRd;
    logic [63:0] m, rise, pexp;
    int nb;
    nb = word ? 32 : 8;
    if (word && off[1:0] != 2'b00) nb = 0;
    pexp  = expPend();
    expRd = '0;
    m     = '0;
    for (int k = 0; k < nb; k++) begin
      int id;
      id = int'(off) * 8 + k;
      if (id < N) begin
        expRd[k] = (win < 2'd2) ? enM[id] : pexp[id];
        if (data[k]) m[id] = 1'b1;
      end
    end
    reqValid = 1'b1; reqWrite = wr; reqAddr = {win, off}; reqWord = word;
    reqWdata = data; line = newLine;
    @(posedge clk);
    rise = line & ~lineQm & ~LVL;
    if (wr) begin
      case (win)
        2'd0: enM = enM | m;
        2'd1: enM = enM & ~m;
        2'd2: begin pendM = pendM | (m & ~LVL); softM = softM | (m & LVL); end
        default: begin pendM = pendM & ~(m & ~LVL); softM = softM & ~(m & LVL); end
      endcase
    end
    pendM  = pendM | rise;
    lineQm = line;
    @(negedge clk);
    reqValid = 1'b0;
    chk(rdValid == !wr, {tag, " R12 rdValid"}, 64'(rdValid), 64'(!wr));
    if (!wr) chk(rdData == expRd, {tag, " rdData"}, 64'(rdData), 64'(expRd));
    chk(enOut == enM, {tag, " enOut"}, enOut, enM);
    chk(pendOut == expPend(), {tag, " pendOut"}, pendOut, expPend());
  endtask

  task automatic idle(input logic [63:0] newLine, input string tag);
    logic [63:0] rise;
    reqValid = 1'b0; line = newLine;
    @(posedge clk);
    rise   = line & ~lineQm & ~LVL;
    pendM  = pendM | rise;
    lineQm = line;
    @(negedge clk);
    chk(enOut == enM, {tag, " enOut"}, enOut, enM);
    chk(pendOut == expPend(), {tag, " pendOut"}, pendOut, expPend());
  endtask

  initial begin
    #(5.0 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; reqValid = 1'b0; reqWrite = 1'b0; reqWord = 1'b0;
    reqAddr = '0; reqWdata = '0; line = '0;
    enM = '0; pendM = '0; softM = '0; lineQm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(enOut == '0, "R1 enOut", enOut, '0);
    chk(pendOut == '0, "R1 pendOut", pendOut, '0);
    access(1'b0, 2'd0, 4'd0, 1'b1, '0, '0, "R1 readback");

    // R2, R4, R5: set-enable byte sweep including IDs beyond NUM_IRQ
    for (int o = 0; o < 16; o++)
      access(1'b1, 2'd0, 4'(o), 1'b0, 32'hFFFF_FF00 | 32'((o * 37 + 5) & 8'hFF), line, "R2 R5 set-en byte");
    for (int o = 0; o < 16; o++) begin
      access(1'b0, 2'd0, 4'(o), 1'b0, '0, line, "R4 R5 read en win0");
      access(1'b0, 2'd1, 4'(o), 1'b0, '0, line, "R4 read en win1");
    end
    for (int o = 0; o < 16; o += 4)
      access(1'b0, 2'd1, 4'(o), 1'b1, '0, line, "R4 R5 read en word");

    // R3: clear-enable, byte and word
    access(1'b1, 2'd1, 4'd2, 1'b0, 32'h0000_00F0, line, "R3 clr-en byte");
    access(1'b1, 2'd1, 4'd4, 1'b1, 32'h8001_00FF, line, "R3 clr-en word");
    access(1'b1, 2'd0, 4'd0, 1'b1, 32'h0000_0000, line, "R2 zero write");
    for (int o = 0; o < 16; o += 4)
      access(1'b0, 2'd0, 4'(o), 1'b1, '0, line, "R3 read en word");

    // R6: misaligned word access
    for (int a = 1; a < 4; a++) begin
      access(1'b1, 2'd1, 4'(a), 1'b1, 32'hFFFF_FFFF, line, "R6 misaligned clr");
      access(1'b1, 2'd0, 4'(a + 4), 1'b1, 32'hFFFF_FFFF, line, "R6 misaligned set");
      access(1'b0, 2'd0, 4'(a), 1'b1, '0, line, "R6 misaligned read");
    end

    // R10: lines drive pending
    idle(64'h0F0F_F0F0_0F0F_F0F0, "R10 lines rise");
    idle(64'h0F0F_F0F0_0F0F_F0F0, "R10 lines hold");
    idle(64'h0000_0000_0000_0000, "R10 lines fall");
    for (int o = 0; o < 8; o++)
      access(1'b0, 2'd2, 4'(o), 1'b0, '0, line, "R10 R12 read pend win2");

    // R8: clear edge pending
    access(1'b1, 2'd3, 4'd0, 1'b1, 32'hFFFF_FFFF, line, "R8 clr-pend word0");
    access(1'b1, 2'd3, 4'd4, 1'b1, 32'hFFFF_FFFF, line, "R8 clr-pend word4");

    // R7: set-pending, level latch survives line low
    access(1'b1, 2'd2, 4'd0, 1'b1, 32'hA5A5_A5A5, line, "R7 set-pend word0");
    access(1'b1, 2'd2, 4'd5, 1'b0, 32'h0000_00C3, line, "R7 set-pend byte5");
    idle(64'h0, "R7 latch holds");
    for (int o = 0; o < 8; o++)
      access(1'b0, 2'd3, 4'(o), 1'b0, '0, line, "R7 R12 read pend win3");

    // R9: clear-pending on level falls back to line
    idle(64'h0300_0300_0300_0300, "R9 level lines high");
    access(1'b1, 2'd3, 4'd0, 1'b1, 32'hFFFF_FFFF, line, "R9 clr-pend level word0");
    access(1'b1, 2'd3, 4'd4, 1'b1, 32'hFFFF_FFFF, line, "R9 clr-pend level word4");
    idle(64'h0100_0000_0100_0000, "R9 level follows line");
    access(1'b0, 2'd2, 4'd0, 1'b1, '0, line, "R9 read pend word0");
    access(1'b0, 2'd2, 4'd4, 1'b1, '0, line, "R9 read pend word4");

    // R11: edge rise in same cycle as clear-pending
    idle(64'h0, "R11 prep low");
    access(1'b1, 2'd2, 4'd0, 1'b1, 32'h0000_000F, 64'h0, "R11 prep set");
    access(1'b1, 2'd3, 4'd0, 1'b1, 32'h0000_000F, 64'h0000_0000_0000_0005, "R11 rise vs clear");
    chk(pendOut[0] == 1'b1 && pendOut[2] == 1'b1 && pendOut[1] == 1'b0,
        "R11 edge kept", pendOut, expPend());
    access(1'b0, 2'd3, 4'd0, 1'b0, '0, line, "R11 read");

    // R1: reset again clears everything
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    enM = '0; pendM = '0; softM = '0; lineQm = '0;
    line = '0;
    @(posedge clk);
    @(negedge clk);
    chk(enOut == '0, "R1 re-reset enOut", enOut, '0);
    chk(pendOut == '0, "R1 re-reset pendOut", pendOut, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule